// File: doc/BRIEF.md
# Serial Control Register Bank with Linear Attenuator

This block takes command words from a host controller over a three-wire link: a latch strobe, a shift clock and a data line. Each 13-bit word carries a short prefix that picks one of three register banks. The first bank holds a 12-bit attenuation code. The second bank holds six output-format flags. The third bank holds six bass-processing flags. The block decodes the words into these banks. It also scales a stream of signed 16-bit audio samples by the linear gain code/4095.

A mode pin reuses the same four control pins as plain level inputs. When the mode pin is high, those pins drive soft mute, de-emphasis and the two-bit bass mode directly. The serial banks are then bypassed and left untouched. The block's outputs are the flags and the scaled samples. The filters and dynamics stages that consume the flags live elsewhere.

All pins are brought into the system clock domain through two-flop synchronizers. A three-state machine handles reception. In `RX_IDLE` it waits for a shift edge; the first shift edge (transition *start*) moves it to `RX_SHIFT`. In `RX_SHIFT` it collects bits. A latch edge with a full word gives transition *accept* into `RX_COMMIT`. A latch edge with a short word gives transition *discard* back to `RX_IDLE`. Raising the mode pin gives transition *abort* back to `RX_IDLE`. `RX_COMMIT` lasts one cycle, writes the bank and returns to `RX_IDLE` (transition *done*).

Top module: `serial_ctrl_atten`

## Requirements
- R1: After reset in serial mode, the attenuation code is 0 so every scaled sample is 0, and all twelve flags read 0.
- R2: In serial mode, `pin_c` is sampled on each rising edge of `pin_b`. The first bit taken is D00 and the thirteenth is D12. The word is applied only on the next rising edge of `pin_a`.
- R3: A word with D12=0 loads D11..D00 as the attenuation code.
- R4: A word with D12=1 and D11=0 loads the format flags: D10 `deemph_en`, D9 `mono_en`, D8 `chan_sel`, D7 `lr_swap`, D6 `comp_deep`, D5 `dyn_off`. D04..D00 are ignored.
- R5: A word with D12=1 and D11=1 loads the bass flags: D10 `bass_mode[1]`, D9 `bass_mode[0]`, D8 `bass_mega`, D7 `bass_mute`, D6 `attack_slow`, D5 `recover_slow`. D04..D00 are ignored.
- R6: A word written to one bank leaves the other two banks unchanged.
- R7: A latch edge after fewer than 13 shift edges discards the word. After more than 13 shift edges, the last 13 bits received form the word.
- R8: A sample accepted with `smp_valid` appears on `smp_out` with `smp_out_valid` exactly 3 clock cycles later. Its value is sample*code/4095 truncated toward zero, saturated to 16 bits. Code 4095 passes the sample unchanged; code 0 gives 0.
- R9: With `par_mode` high: `soft_mute`=`pin_a`, `deemph_en`=`pin_b`, `bass_mode`={`pin_c`,`pin_d`}, all other flags are 0 and the gain is unity. Pin activity in this mode does not alter the serial banks; their values return when `par_mode` goes low.
- R10: `soft_mute` is 0 in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | 1 = pin-strap mode, 0 = serial mode |
| pin_a | input | 1 | Latch strobe (serial) / soft mute (parallel) |
| pin_b | input | 1 | Shift clock (serial) / de-emphasis (parallel) |
| pin_c | input | 1 | Serial data (serial) / bass mode bit 1 (parallel) |
| pin_d | input | 1 | Bass mode bit 0 (parallel), unused in serial |
| smp_valid | input | 1 | Input sample strobe |
| smp_in | input | 16 | Signed input sample |
| smp_out_valid | output | 1 | Output sample strobe |
| smp_out | output | 16 | Signed scaled sample |
| soft_mute | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| mono_en | output | 1 | Mono output enable |
| chan_sel | output | 1 | Mono channel select |
| lr_swap | output | 1 | Word-clock polarity swap |
| comp_deep | output | 1 | Deeper compressor characteristic |
| dyn_off | output | 1 | Dynamics stage disable |
| bass_mode | output | 2 | Bass boost mode |
| bass_mega | output | 1 | Extended bass boost |
| bass_mute | output | 1 | Bass path mute |
| attack_slow | output | 1 | Long attack time |
| recover_slow | output | 1 | Long recovery time |

## Verification
The hardest case to reach from the ports is serial-bank isolation during pin-strap mode. The shift and latch lines toggle as ordinary level pins there, and nothing visible changes while `par_mode` stays high. The bench first writes known values to all three banks. It then enters parallel mode and clocks a complete bank-selecting word through `pin_b`/`pin_a`. Finally it drops `par_mode` and checks that the earlier flags and gain are back. Short and long words are driven with explicit bit counts, so the discard and last-13 rules are exercised apart from normal writes.

// File: rtl/sca_pkg.sv
package sca_pkg;
    localparam int WORD_W = 13;
    localparam int CODE_W = 12;
    localparam int FLAG_W = 6;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_COMMIT
    } rx_state_t;

    typedef struct packed {
        logic deemph;
        logic mono;
        logic chan_sel;
        logic lr_swap;
        logic comp_deep;
        logic dyn_off;
    } mode_flags_t;

    typedef struct packed {
        logic [1:0] bass_mode;
        logic       mega;
        logic       bmute;
        logic       attack_slow;
        logic       recover_slow;
    } bass_flags_t;
endpackage

// File: rtl/sca_sync.sv
module sca_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sca_serial_rx.sv
module sca_serial_rx
    import sca_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par,
    input  logic         latch_s,
    input  logic         shift_s,
    input  logic         data_s,
    output logic         commit,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    rx_state_t        st, nxt;
    logic             shift_d, latch_d;
    logic             sh_rise, la_rise;
    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;

    assign sh_rise = shift_s & ~shift_d;
    assign la_rise = latch_s & ~latch_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_d <= 1'b0;
            latch_d <= 1'b0;
        end else begin
            shift_d <= shift_s;
            latch_d <= latch_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt    = st;
        commit = 1'b0;
        unique case (st)
            RX_IDLE: begin
                if (!par && sh_rise) nxt = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (par)          nxt = RX_IDLE;
                else if (la_rise) nxt = (cnt == FULL) ? RX_COMMIT : RX_IDLE;
            end
            RX_COMMIT: begin
                commit = 1'b1;
                nxt    = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // bit collection: newest bit enters at the top, so D00 ends at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (par) begin
            cnt <= '0;
        end else if (st == RX_IDLE && sh_rise) begin
            sreg <= {data_s, sreg[W-1:1]};
            cnt  <= CNT_W'(1);
        end else if (st == RX_SHIFT && !la_rise && sh_rise) begin
            sreg <= {data_s, sreg[W-1:1]};
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end
    end

    assign word = sreg;

    p_commit_from_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_COMMIT) |-> ($past(st) == RX_SHIFT));
    p_full_word_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_SHIFT && nxt == RX_COMMIT) |-> (cnt == FULL));
    p_par_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par |=> (st == RX_IDLE));
endmodule

// File: rtl/sca_bank_regs.sv
module sca_bank_regs
    import sca_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [W-1:0]  word,
    input  logic          par,
    input  logic          par_a,
    input  logic          par_b,
    input  logic          par_c,
    input  logic          par_d,
    output logic [CW-1:0] gain_code,
    output mode_flags_t   mode_o,
    output bass_flags_t   bass_o,
    output logic          soft_mute
);
    localparam int FLAG_HI = W - 3;
    localparam int FLAG_LO = FLAG_HI - FLAG_W + 1;

    logic [CW-1:0] atten_q;
    mode_flags_t   mode_q;
    bass_flags_t   bass_q;
    logic          sel_atten, sel_mode, sel_bass;

    assign sel_atten = commit & ~word[W-1];
    assign sel_mode  = commit &  word[W-1] & ~word[W-2];
    assign sel_bass  = commit &  word[W-1] &  word[W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            atten_q <= '0;
            mode_q  <= '0;
            bass_q  <= '0;
        end else begin
            if (sel_atten) atten_q <= word[CW-1:0];
            if (sel_mode)  mode_q  <= mode_flags_t'(word[FLAG_HI:FLAG_LO]);
            if (sel_bass)  bass_q  <= bass_flags_t'(word[FLAG_HI:FLAG_LO]);
        end
    end

    always_comb begin
        if (par) begin
            gain_code        = '1;
            mode_o           = '0;
            mode_o.deemph    = par_b;
            bass_o           = '0;
            bass_o.bass_mode = {par_c, par_d};
            soft_mute        = par_a;
        end else begin
            gain_code = atten_q;
            mode_o    = mode_q;
            bass_o    = bass_q;
            soft_mute = 1'b0;
        end
    end

    p_atten_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_atten |=> $stable(atten_q));
    p_flag_banks_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_atten |=> ($stable(mode_q) && $stable(bass_q)));
    p_no_serial_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !par |-> !soft_mute);
endmodule

// File: rtl/sca_atten_pipe.sv
module sca_atten_pipe #(
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [CW-1:0]        code,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int PW    = DW + CW + 1;
    localparam int MW    = DW + CW;
    localparam int SH    = MW + CW;
    localparam int RW    = MW + 1;
    localparam int QW    = DW + 1;
    localparam logic [63:0] DIV   = (64'd1 << CW) - 64'd1;
    localparam logic [63:0] RECIP = ((64'd1 << SH) + DIV - 64'd1) / DIV;
    localparam logic [RW-1:0] RECIP_T = RECIP[RW-1:0];
    localparam logic signed [QW:0] S_MAX = (QW+1)'((64'd1 << (DW-1)) - 64'd1);
    localparam logic signed [QW:0] S_MIN = -(QW+1)'(64'd1 << (DW-1));

    logic                 v1, v2;
    logic signed [PW-1:0] prod1;
    logic                 neg2;
    logic [QW-1:0]        quot2;
    logic                 neg1;
    logic [MW-1:0]        mag1;
    logic [2*MW:0]        full1;
    logic signed [QW:0]   sres;

    // stage 1: signed product
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            prod1 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) prod1 <= PW'(in_data * $signed({1'b0, code}));
        end
    end

    // stage 2: magnitude times reciprocal gives floor(|p|/DIV)
    always_comb begin
        neg1  = prod1[PW-1];
        mag1  = neg1 ? MW'(-prod1) : MW'(prod1);
        full1 = {{(MW+1){1'b0}}, mag1} * {{MW{1'b0}}, RECIP_T};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2    <= 1'b0;
            neg2  <= 1'b0;
            quot2 <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                neg2  <= neg1;
                quot2 <= full1[SH +: QW];
            end
        end
    end

    // stage 3: restore sign (truncation toward zero) and saturate
    always_comb begin
        sres = neg2 ? -$signed({1'b0, quot2}) : $signed({1'b0, quot2});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v2;
            if (v2) begin
                if (sres > S_MAX)      out_data <= S_MAX[DW-1:0];
                else if (sres < S_MIN) out_data <= S_MIN[DW-1:0];
                else                   out_data <= sres[DW-1:0];
            end
        end
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    p_mute_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code == '0) |-> ##3 (out_data == '0));
    p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data >= 0) |-> ##3 (out_data >= 0));
endmodule

// File: rtl/serial_ctrl_atten.sv
module serial_ctrl_atten
    import sca_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_c,
    input  logic              pin_d,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_in,
    output logic              smp_out_valid,
    output logic [DATA_W-1:0] smp_out,
    output logic              soft_mute,
    output logic              deemph_en,
    output logic              mono_en,
    output logic              chan_sel,
    output logic              lr_swap,
    output logic              comp_deep,
    output logic              dyn_off,
    output logic [1:0]        bass_mode,
    output logic              bass_mega,
    output logic              bass_mute,
    output logic              attack_slow,
    output logic              recover_slow
);
    localparam int NPIN = 5;

    logic [NPIN-1:0]   pins_s;
    logic              par_s, a_s, b_s, c_s, d_s;
    logic              commit;
    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] gain_code;
    mode_flags_t       mode_o;
    bass_flags_t       bass_o;
    logic signed [DATA_W-1:0] out_s;

    sca_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({par_mode, pin_a, pin_b, pin_c, pin_d}),
        .q     (pins_s)
    );
    assign {par_s, a_s, b_s, c_s, d_s} = pins_s;

    sca_serial_rx #(.W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .par     (par_s),
        .latch_s (a_s),
        .shift_s (b_s),
        .data_s  (c_s),
        .commit  (commit),
        .word    (word)
    );

    sca_bank_regs #(.W(WORD_W), .CW(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .word      (word),
        .par       (par_s),
        .par_a     (a_s),
        .par_b     (b_s),
        .par_c     (c_s),
        .par_d     (d_s),
        .gain_code (gain_code),
        .mode_o    (mode_o),
        .bass_o    (bass_o),
        .soft_mute (soft_mute)
    );

    sca_atten_pipe #(.DW(DATA_W), .CW(CODE_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   ($signed(smp_in)),
        .code      (gain_code),
        .out_valid (smp_out_valid),
        .out_data  (out_s)
    );
    assign smp_out = out_s;

    assign deemph_en    = mode_o.deemph;
    assign mono_en      = mode_o.mono;
    assign chan_sel     = mode_o.chan_sel;
    assign lr_swap      = mode_o.lr_swap;
    assign comp_deep    = mode_o.comp_deep;
    assign dyn_off      = mode_o.dyn_off;
    assign bass_mode    = bass_o.bass_mode;
    assign bass_mega    = bass_o.mega;
    assign bass_mute    = bass_o.bmute;
    assign attack_slow  = bass_o.attack_slow;
    assign recover_slow = bass_o.recover_slow;
endmodule

// File: tb/serial_ctrl_atten_test.sv
module serial_ctrl_atten_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_mode = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0, pin_d = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_in = '0;
    logic        smp_out_valid;
    logic [15:0] smp_out;
    logic        soft_mute, deemph_en, mono_en, chan_sel, lr_swap, comp_deep, dyn_off;
    logic [1:0]  bass_mode;
    logic        bass_mega, bass_mute, attack_slow, recover_slow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serial_ctrl_atten uut (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d),
        .smp_valid(smp_valid), .smp_in(smp_in),
        .smp_out_valid(smp_out_valid), .smp_out(smp_out),
        .soft_mute(soft_mute), .deemph_en(deemph_en), .mono_en(mono_en),
        .chan_sel(chan_sel), .lr_swap(lr_swap), .comp_deep(comp_deep),
        .dyn_off(dyn_off), .bass_mode(bass_mode), .bass_mega(bass_mega),
        .bass_mute(bass_mute), .attack_slow(attack_slow), .recover_slow(recover_slow)
    );

    function automatic logic [5:0] mode_v();
        return {deemph_en, mono_en, chan_sel, lr_swap, comp_deep, dyn_off};
    endfunction
    function automatic logic [5:0] bass_v();
        return {bass_mode, bass_mega, bass_mute, attack_slow, recover_slow};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send n bits of w, bit 0 first, then strobe the latch
    task automatic send(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            pin_c = w[i];
            wait_clk(3);
            pin_b = 1'b1;
            wait_clk(3);
            pin_b = 1'b0;
            wait_clk(3);
        end
        pin_a = 1'b1;
        wait_clk(3);
        pin_a = 1'b0;
        wait_clk(8);
    endtask

    // apply one sample and check value and 3-cycle latency
    task automatic sample(input string req, input int s, input int code);
        int exp;
        exp = (s * code) / 4095;
        @(negedge clk);
        smp_in = 16'(s);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk({req, " early valid"}, int'(smp_out_valid), 0);
        @(negedge clk);
        chk({req, " valid"}, int'(smp_out_valid), 1);
        chk({req, " value"}, int'($signed(smp_out)), exp);
    endtask

    task automatic t_reset();
        chk("R1 mode flags", int'(mode_v()), 0);
        chk("R1 bass flags", int'(bass_v()), 0);
        chk("R10 soft mute", int'(soft_mute), 0);
        sample("R1 muted", 12000, 0);
    endtask

    task automatic t_atten();
        send(16'h0FFF, 13);
        sample("R8 unity pos", 32767, 4095);
        sample("R8 unity neg", -32768, 4095);
        send(16'h0800, 13);
        sample("R3 half pos", 10001, 2048);
        sample("R8 trunc neg", -10001, 2048);
        send(16'h0001, 13);
        sample("R3 min code", 32767, 1);
        sample("R8 min code neg", -32768, 1);
        send(16'h0ABC, 13);
        sample("R2 order", -1234, 12'hABC);
        send(16'h0000, 13);
        sample("R8 mute", -32768, 0);
        send(16'h0C80, 13);
    endtask

    task automatic t_mode();
        send(16'h1000 | (16'b101101 << 5) | 16'h001F, 13);
        chk("R4 mode bits", int'(mode_v()), 6'b101101);
        chk("R6 bass untouched", int'(bass_v()), 0);
        sample("R6 atten kept", 20000, 12'hC80);
    endtask

    task automatic t_bass();
        send(16'h1800 | (16'b110011 << 5) | 16'h0015, 13);
        chk("R5 bass bits", int'(bass_v()), 6'b110011);
        chk("R6 mode kept", int'(mode_v()), 6'b101101);
        send(16'h1800 | (16'b011110 << 5), 13);
        chk("R5 bass bits 2", int'(bass_v()), 6'b011110);
    endtask

    task automatic t_length();
        send(16'h0123, 12);
        sample("R7 short discarded", 20000, 12'hC80);
        // 16 bits: last 13 are w[15:3]; w[15:3] = 0_0000_0100_0000 -> code 0x040
        send(16'h0200 | 16'h0007, 16);
        sample("R7 long keeps last", 30000, 12'h040);
    endtask

    task automatic t_parallel();
        par_mode = 1'b1;
        pin_a = 1'b1; pin_b = 1'b0; pin_c = 1'b1; pin_d = 1'b0;
        wait_clk(6);
        chk("R9 soft mute", int'(soft_mute), 1);
        chk("R9 deemph", int'(deemph_en), 0);
        chk("R9 mode others", int'(mode_v()), 0);
        chk("R9 bass pins", int'(bass_v()), 6'b100000);
        sample("R9 unity", -7777, 4095);
        pin_a = 1'b0; pin_b = 1'b1; pin_c = 1'b0; pin_d = 1'b1;
        wait_clk(6);
        chk("R9 deemph pin", int'(deemph_en), 1);
        chk("R9 soft mute off", int'(soft_mute), 0);
        chk("R9 bass pins 2", int'(bass_v()), 6'b010000);
        pin_b = 1'b0;
        wait_clk(4);
        // full mode-bank word clocked while strapped: must be ignored
        send(16'h1000 | (16'b010010 << 5), 13);
        send(16'h0005, 13);
        pin_a = 1'b0; pin_b = 1'b0; pin_c = 1'b0; pin_d = 1'b0;
        wait_clk(2);
        par_mode = 1'b0;
        wait_clk(6);
        chk("R9 mode restored", int'(mode_v()), 6'b101101);
        chk("R9 bass restored", int'(bass_v()), 6'b011110);
        chk("R10 mute serial", int'(soft_mute), 0);
        sample("R9 gain restored", 30000, 12'h040);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_atten();
        t_mode();
        t_bass();
        t_length();
        t_parallel();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule